// File: doc/BRIEF.md
# Colour Subcarrier Oscillator with Genlock Serial Link

This block generates the phase of a colour subcarrier with a 23-bit phase accumulator. Each system clock it adds a frequency control word, so the output frequency is the control word divided by 2^23, multiplied by the clock frequency. The lowest bit of the word is always treated as zero.

Once per scan line, a single serial output carries the control word to a slave device so that it can lock its own oscillator. After a short lead-in, the block sends a start bit, then the word MSB first, one bit per clock. Eight clocks after the last word bit it sends a reset slot. A host can ask for a subcarrier phase reset by writing a control register. On the next line the reset slot is driven low, and on that same clock edge the local accumulator returns to zero. The request then clears itself.

Top module: `chroma_genlock_osc`

## Requirements
- R1: While `rst_n` is low, `syncOut` is 1 and `phaseAcc` is 0.
- R2: On every clock edge that is not a reset-slot clear, `phaseAcc` becomes its previous value plus the masked control word, modulo 2^23.
- R3: Bit 0 of `freqWord` is used as 0, both in the accumulation and in the transmitted word.
- R4: The bench calls the edge that samples an accepted `lineStart` high edge 0. Then `syncOut` carries slot c (c from 0) after edge c+1. Slots 0..3 are 1, slot 4 is a start bit of 1, and slots 5..27 are `freqWord` bits 22 down to 0, using the value latched at edge 0.
- R5: `syncOut` is 1 when no frame is in progress, and in gap slots 28..34.
- R6: Slot 35, which comes 8 clocks after the last word bit, is 0 when a reset was requested for that line, and 1 otherwise.
- R7: On the edge that drives slot 35 low, `phaseAcc` becomes 0. Accumulation resumes on the following edge.
- R8: A write with `regAddr` = 0x1A and `regWrData` bit 4 = 1 requests a reset. A write to another address, or one with bit 4 = 0, has no effect.
- R9: A request made while a frame is in progress is served on the following line. A request that has been served is cleared, so the next line has slot 35 high.
- R10: A `lineStart` pulse during a frame is ignored, and that frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-clock scan line start strobe |
| freqWord | input | 23 | Frequency control word |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 8 | Host register address |
| regWrData | input | 8 | Host register write data |
| phaseAcc | output | 23 | Subcarrier phase accumulator |
| syncOut | output | 1 | Serial genlock line, idles high |

## Verification
The bench sets an all-ones word so that the accumulator wraps within a few clocks, and it checks that bit 0 never reaches the sum or the line. A design that forgot the mask, or that saturated the sum, would drift by one count per clock or stick at full scale. Every frame is compared bit by bit against slot positions worked out from the line-start edge, so an off-by-one lead-in, LSB-first order or a reset slot at the wrong distance shows up as a misplaced bit.

Requests are sent in the middle of a frame together with a stray line start. A design that served a request on the current line, restarted the frame, or failed to clear a served request would show the low reset slot on the wrong line. Writes to a neighbouring address and writes with the request bit clear must leave the reset slot high.

// File: rtl/cgo_pkg.sv
package cgo_pkg;
  typedef enum logic [1:0] {
    SLOT_HI   = 2'd0,
    SLOT_WORD = 2'd1,
    SLOT_RST  = 2'd2
  } slotKind_e;

  typedef struct packed {
    logic      load;
    slotKind_e kind;
    logic      phaseClr;
  } ctrlStrb_t;
endpackage

// File: rtl/cgo_ctrl.sv
module cgo_ctrl
  import cgo_pkg::*;
#(
  parameter int FW       = 23,
  parameter int LEAD     = 4,
  parameter int GAP      = 8,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int REQ_ADDR = 8'h1A,
  parameter int REQ_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lineStart,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output ctrlStrb_t     strb
);
  localparam int LAST_SLOT = LEAD + FW;
  localparam int RST_SLOT  = LAST_SLOT + GAP;
  localparam int CW        = $clog2(RST_SLOT + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          reqPending;
  logic          lineReq;
  logic          newReq;
  logic          accept;
  logic          atRst;

  assign newReq = regWrEn && (regAddr == AW'(REQ_ADDR)) && regWrData[REQ_BIT];
  assign accept = !busy && lineStart;
  assign atRst  = busy && (cnt == CW'(RST_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      reqPending <= 1'b0;
      lineReq    <= 1'b0;
    end else begin
      if (accept) begin
        busy       <= 1'b1;
        cnt        <= '0;
        lineReq    <= reqPending;
        reqPending <= newReq;
      end else begin
        reqPending <= reqPending | newReq;
        if (atRst) begin
          busy    <= 1'b0;
          lineReq <= 1'b0;
        end else if (busy) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.load     = accept;
    strb.kind     = SLOT_HI;
    strb.phaseClr = 1'b0;
    if (busy) begin
      if (cnt > CW'(LEAD) && cnt <= CW'(LAST_SLOT)) begin
        strb.kind = SLOT_WORD;
      end else if (cnt == CW'(RST_SLOT)) begin
        strb.kind     = SLOT_RST;
        strb.phaseClr = lineReq;
      end
    end
  end
endmodule

// File: rtl/cgo_datapath.sv
module cgo_datapath
  import cgo_pkg::*;
#(
  parameter int FW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freqWord,
  input  ctrlStrb_t     strb,
  output logic [FW-1:0] phaseAcc,
  output logic          syncOut
);
  logic [FW-1:0] maskedWord;
  logic [FW-1:0] shiftReg;

  assign maskedWord = {freqWord[FW-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseAcc <= '0;
    end else if (strb.phaseClr) begin
      phaseAcc <= '0;
    end else begin
      phaseAcc <= phaseAcc + maskedWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '0;
      syncOut  <= 1'b1;
    end else begin
      if (strb.load) begin
        shiftReg <= maskedWord;
      end else if (strb.kind == SLOT_WORD) begin
        shiftReg <= {shiftReg[FW-2:0], 1'b0};
      end
      case (strb.kind)
        SLOT_WORD: syncOut <= shiftReg[FW-1];
        SLOT_RST:  syncOut <= !strb.phaseClr;
        default:   syncOut <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/chroma_genlock_osc.sv
module chroma_genlock_osc
  import cgo_pkg::*;
#(
  parameter int FW       = 23,
  parameter int LEAD     = 4,
  parameter int GAP      = 8,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int REQ_ADDR = 8'h1A,
  parameter int REQ_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lineStart,
  input  logic [FW-1:0] freqWord,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [FW-1:0] phaseAcc,
  output logic          syncOut
);
  ctrlStrb_t strb;

  cgo_ctrl #(
    .FW(FW), .LEAD(LEAD), .GAP(GAP), .AW(AW), .DW(DW),
    .REQ_ADDR(REQ_ADDR), .REQ_BIT(REQ_BIT)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .lineStart(lineStart),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strb(strb)
  );

  cgo_datapath #(.FW(FW)) dp_i (
    .clk(clk), .rst_n(rst_n), .freqWord(freqWord), .strb(strb),
    .phaseAcc(phaseAcc), .syncOut(syncOut)
  );
endmodule

// File: rtl/chroma_genlock_osc_checker.sv
module chroma_genlock_osc_checker
  import cgo_pkg::*;
#(
  parameter int FW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic [FW-1:0] freqWord,
  input logic [FW-1:0] phaseAcc,
  input logic          syncOut,
  input ctrlStrb_t     strb
);
  logic [FW-1:0] evenWord;
  assign evenWord = {freqWord[FW-1:1], 1'b0};

  // R2: accumulation modulo 2^FW
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.phaseClr |=> phaseAcc == FW'($past(phaseAcc) + $past(evenWord)));

  // R3: the sum never picks up bit 0
  assert_acc_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phaseAcc[0] == 1'b0);

  // R5: high slots drive the line high
  assert_high_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.kind == SLOT_HI |=> syncOut);

  // R6: reset slot with no request stays high
  assert_rst_slot_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.kind == SLOT_RST && !strb.phaseClr) |=> syncOut);

  // R7: line low and accumulator zero on the same edge
  assert_clear_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.phaseClr |=> (phaseAcc == '0 && !syncOut));
endmodule

bind chroma_genlock_osc chroma_genlock_osc_checker #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .freqWord(freqWord),
  .phaseAcc(phaseAcc), .syncOut(syncOut), .strb(strb)
);

// File: tb/chroma_genlock_osc_tb.sv
module chroma_genlock_osc_tb_top;
  localparam int FW = 23;
  localparam int LEAD = 4;
  localparam int LAST = LEAD + FW;
  localparam int RSTS = LAST + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lineStart = 1'b0;
  logic [FW-1:0] freqWord = '0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regAddr = '0;
  logic [7:0]    regWrData = '0;
  logic [FW-1:0] phaseAcc;
  logic          syncOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chroma_genlock_osc dut_i (
    .clk(clk), .rst_n(rst_n), .lineStart(lineStart), .freqWord(freqWord),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .phaseAcc(phaseAcc), .syncOut(syncOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Runs one frame; optional mid-frame request write and stray line start.
  task automatic runFrame(input logic [FW-1:0] w, input bit expReq,
                          input int reqAt, input int strayAt);
    logic [FW-1:0] mw;
    logic [FW-1:0] prev;
    logic expBit;
    mw = {w[FW-1:1], 1'b0};
    freqWord = w;
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    prev = phaseAcc;
    for (int i = 0; i <= RSTS; i++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      lineStart = 1'b0;
      if (i <= LEAD) expBit = 1'b1;
      else if (i <= LAST) expBit = mw[FW-1-(i-LEAD-1)];
      else if (i < RSTS) expBit = 1'b1;
      else expBit = !expReq;
      if (i <= LAST) check(syncOut == expBit, "R4 frame bit", syncOut, expBit);
      else if (i < RSTS) check(syncOut == expBit, "R5 gap slot", syncOut, expBit);
      else check(syncOut == expBit, "R6 reset slot", syncOut, expBit);
      if (i == RSTS && expReq)
        check(phaseAcc == 0, "R7 accumulator cleared", phaseAcc, 0);
      else
        check(phaseAcc == FW'(prev + mw), "R2 accumulate", phaseAcc, FW'(prev + mw));
      prev = phaseAcc;
      if (i == reqAt) begin regWrEn = 1'b1; regAddr = 8'h1A; regWrData = 8'h10; end
      if (i == strayAt) lineStart = 1'b1;
    end
    regWrEn = 1'b0;
    lineStart = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(syncOut == 1'b1, "R5 idle high", syncOut, 1);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(syncOut == 1'b1, "R1 reset line", syncOut, 1);
    check(phaseAcc == 0, "R1 reset acc", phaseAcc, 0);
    freqWord = 23'h7FFFFF;
    rst_n = 1'b1;
    begin
      logic [FW-1:0] prev;
      prev = phaseAcc;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        check(phaseAcc == FW'(prev + 23'h7FFFFE), "R2 R3 wrap with masked bit 0",
              phaseAcc, FW'(prev + 23'h7FFFFE));
        check(syncOut == 1'b1, "R5 idle high", syncOut, 1);
        prev = phaseAcc;
      end
    end
  endtask

  task automatic t_patterns;
    runFrame(23'h2AAAAA, 1'b0, -1, -1);  // R4
    runFrame(23'h555555, 1'b0, -1, -1);  // R3 odd word sends bit 0 as 0
    runFrame(23'h400001, 1'b0, -1, -1);  // R4 MSB first
  endtask

  task automatic t_request;
    hostWrite(8'h1A, 8'h10);              // R8
    runFrame(23'h123457, 1'b1, -1, -1);   // R6 R7
    runFrame(23'h123457, 1'b0, -1, -1);   // R9 cleared after use
  endtask

  task automatic t_noEffect;
    hostWrite(8'h1A, 8'hEF);              // R8 bit 4 clear
    hostWrite(8'h1B, 8'h10);              // R8 other address
    runFrame(23'h0F0F0F, 1'b0, -1, -1);
  endtask

  task automatic t_midFrame;
    runFrame(23'h3C3C3D, 1'b0, 10, 14);   // R9 held, R10 stray start ignored
    runFrame(23'h3C3C3D, 1'b1, -1, -1);   // R9 served on following line
  endtask

  initial begin
    t_reset;
    t_patterns;
    t_request;
    t_noEffect;
    t_midFrame;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule